// File: doc/BRIEF.md
# I/O-Space Access Unit with Atomic Bit Operations

This block carries out processor I/O operations against a memory-mapped device space. One request names an operation, a width (16-bit word or 8-bit byte), an address, an operand, an accumulator value and the privilege mode of the requester. The unit looks the address up in a small programmable table of base/length windows and selects the device whose window holds it. It then runs one bus cycle, or two for a read-modify-write, on a generic device port. It returns the read value, the skip decision of a test operation, or a fault.

The supported operations are plain read and write, two AND-based test-and-skip variants, and atomic set-bits and clear-bits. Every operation has a word form and a byte form. A byte access reads the aligned word and selects the byte lane from the low address bit. When no window matches, no device cycle is issued. The unit then reports a fault word and records a timeout and a missing-device flag in the status of the adapter named by the address's controller field.

Top module: `iosp_access_unit`

## Requirements
- R1: A window with index i selects the device i for address A when base_i <= A < base_i + len_i. Addresses are 22 bits. The selected index appears on dev_sel, with dev_rd for a read phase and dev_wr for a write phase.
- R2: When several windows match, the one with the lowest index is selected.
- R3: A word write drives operand bits 15:0 on dev_wdata. A byte write drives operand bits 7:0, zero-extended, with dev_byte high and the request address unchanged (bit 0 picks the lane).
- R4: A byte read puts the address with bit 0 cleared on dev_addr. It returns device bits 15:8 when the request address is odd and bits 7:0 when it is even, zero-extended on rd_data.
- R5: Set-bits (op 4) writes back old|operand. Clear-bits (op 5) writes back old&~operand. Each uses the selected width, and a byte form writes one byte at the request address. rd_data returns the old value.
- R6: Test op 2 skips when (acc & value) == 0. Test op 3 skips when it is nonzero. Tests issue one read and no write. The value is the word, or the zero-extended byte for a byte test.
- R7: On a miss no dev_rd or dev_wr is issued and fault is set. fault_word is {user, 1, byte-write flag, address used}. The byte-write flag is set only for a byte write (op 1).
- R8: A miss sets the timeout and missing-device bits of adapter 0 when address bits 21:18 equal 1, and of adapter 1 when they equal 3. Any other controller value changes no adapter. The bits stay set until reset.
- R9: A read-modify-write holds bus_lock from its read phase through its write phase. busy is high from acceptance until done, and requests offered while busy are ignored.
- R10: done is a one-cycle pulse. It comes 2 clock edges after the accepting edge for read, write and test, and 3 for set/clear.
- R11: A window is loaded by cfg_we with cfg_idx, cfg_base and cfg_len. Reset clears every length to 0 (all addresses miss), and clears busy, done and the adapter status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one window |
| cfg_idx | input | 2 | Window index to load |
| cfg_base | input | 22 | Window base address |
| cfg_len | input | 22 | Window length in address units |
| req_valid | input | 1 | Request offered (taken when not busy) |
| req_op | input | 3 | 0 read, 1 write, 2 test-zero, 3 test-nonzero, 4 set-bits, 5 clear-bits |
| req_byte | input | 1 | Byte width when high |
| req_addr | input | 22 | Target address, bits 21:18 controller field |
| req_operand | input | 36 | Write data or bit mask |
| req_acc | input | 36 | Accumulator for tests |
| req_user | input | 1 | Requester is in user mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| rd_data | output | 16 | Value read (zero-extended byte in byte mode) |
| skip | output | 1 | Test result |
| fault | output | 1 | Completed with a decode miss |
| fault_word | output | 25 | Miss report word |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_byte | output | 1 | Device write is one byte |
| dev_sel | output | 2 | Selected window index |
| dev_addr | output | 22 | Device address |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid in the dev_rd cycle |
| bus_lock | output | 1 | Bus held for a read-modify-write |
| adp_tmo | output | 2 | Per-adapter timeout flag |
| adp_nxd | output | 2 | Per-adapter missing-device flag |

## Verification
The embedded properties guard invariants that must hold in every cycle. A selected window must contain the address and no lower window may match it. A locked write must immediately follow a locked read. Byte writes never drive the upper lane, byte reads are aligned, a miss issues no strobe, done stays a single-cycle pulse, and the adapter flags are set after a miss and then stay set. The data results themselves can only be shown by the bench's scenarios. These include the lane extraction, the set/clear merge values, both skip polarities, overlap priority visible in which device storage changed, the exact fault word contents, the ignored request during a locked operation, and the cleared table after reset.

// File: rtl/iosp_pkg.sv
package iosp_pkg;

    localparam int CTRL_W = 4;
    localparam int ADP_N  = 2;

    typedef enum logic [2:0] {
        IOP_RD   = 3'd0,
        IOP_WR   = 3'd1,
        IOP_TSTZ = 3'd2,
        IOP_TSTN = 3'd3,
        IOP_SET  = 3'd4,
        IOP_CLR  = 3'd5
    } iop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_WBACK = 2'd2
    } st_e;

    // controller field to adapter: 1 -> 0, 3 -> 1, others absent
    function automatic logic adp_valid(input logic [CTRL_W-1:0] c);
        return (c == CTRL_W'(1)) || (c == CTRL_W'(3));
    endfunction

    function automatic logic adp_index(input logic [CTRL_W-1:0] c);
        return (c == CTRL_W'(3));
    endfunction

endpackage

// File: rtl/iosp_range_tbl.sv
module iosp_range_tbl #(
    parameter int ADDR_W = 22,
    parameter int NDEV   = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_len,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [SEL_W-1:0]  lk_sel
);

    typedef struct packed {
        logic [NDEV-1:0][ADDR_W-1:0] base;
        logic [NDEV-1:0][ADDR_W-1:0] len;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NDEV-1:0] hit_vec;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we) begin
            tbl_d.base[cfg_idx] = cfg_base;
            tbl_d.len[cfg_idx]  = cfg_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    generate
        for (genvar g = 0; g < NDEV; g++) begin : g_cmp
            logic [ADDR_W:0] end_w;
            assign end_w      = {1'b0, tbl_q.base[g]} + {1'b0, tbl_q.len[g]};
            assign hit_vec[g] = (lk_addr >= tbl_q.base[g]) && ({1'b0, lk_addr} < end_w);
        end
    endgenerate

    always_comb begin
        lk_sel = '0;
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (hit_vec[i]) lk_sel = SEL_W'(i);
        end
        lk_hit = |hit_vec;
    end

    // R1
    sel_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_addr >= tbl_q.base[lk_sel]) &&
                   ((lk_addr - tbl_q.base[lk_sel]) < tbl_q.len[lk_sel]));

    // R2
    lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (hit_vec & ~({NDEV{1'b1}} << lk_sel)) == '0);

endmodule

// File: rtl/iosp_lane.sv
module iosp_lane
    import iosp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPND_W = 36
) (
    input  iop_e              op,
    input  logic              byte_mode,
    input  logic              odd,
    input  logic [DATA_W-1:0] rword,
    input  logic [OPND_W-1:0] operand,
    input  logic [OPND_W-1:0] acc,
    output logic [DATA_W-1:0] rval,
    output logic [DATA_W-1:0] merged,
    output logic              skip
);

    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] opm;
    logic [OPND_W-1:0] andv;

    always_comb begin
        if (byte_mode) begin
            rval = odd ? DATA_W'(rword[DATA_W-1:BYTE_W]) : DATA_W'(rword[BYTE_W-1:0]);
            opm  = DATA_W'(operand[BYTE_W-1:0]);
        end else begin
            rval = rword;
            opm  = operand[DATA_W-1:0];
        end
        case (op)
            IOP_SET: merged = rval | opm;
            IOP_CLR: merged = rval & ~opm;
            default: merged = opm;
        endcase
        andv = acc & OPND_W'(rval);
        case (op)
            IOP_TSTZ: skip = (andv == '0);
            IOP_TSTN: skip = (andv != '0);
            default:  skip = 1'b0;
        endcase
    end

endmodule

// File: rtl/iosp_adp_stat.sv
module iosp_adp_stat
    import iosp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [ADP_N-1:0]  tmo,
    output logic [ADP_N-1:0]  nxd
);

    typedef struct packed {
        logic [ADP_N-1:0] tmo;
        logic [ADP_N-1:0] nxd;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (miss && adp_valid(ctrl)) begin
            st_d.tmo[adp_index(ctrl)] = 1'b1;
            st_d.nxd[adp_index(ctrl)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo = st_q.tmo;
    assign nxd = st_q.nxd;

    generate
        for (genvar g = 0; g < ADP_N; g++) begin : g_chk
            // R8
            miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (miss && adp_valid(ctrl) && (int'(adp_index(ctrl)) == g)) |=> (tmo[g] && nxd[g]));
            // R8
            sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tmo[g] && nxd[g]) |=> (tmo[g] && nxd[g]));
        end
    endgenerate

endmodule

// File: rtl/iosp_access_unit.sv
module iosp_access_unit
    import iosp_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int OPND_W = 36,
    parameter int NDEV   = 4,
    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1,
    localparam int FW_W  = ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_len,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OPND_W-1:0] req_operand,
    input  logic [OPND_W-1:0] req_acc,
    input  logic              req_user,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              skip,
    output logic              fault,
    output logic [FW_W-1:0]   fault_word,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              dev_byte,
    output logic [SEL_W-1:0]  dev_sel,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              bus_lock,
    output logic [ADP_N-1:0]  adp_tmo,
    output logic [ADP_N-1:0]  adp_nxd
);

    localparam int BYTE_W = DATA_W / 2;

    typedef struct packed {
        st_e               st;
        iop_e              op;
        logic              byt;
        logic [ADDR_W-1:0] addr;
        logic [OPND_W-1:0] opnd;
        logic [OPND_W-1:0] acc;
        logic              user;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] tmp;
        logic [DATA_W-1:0] rdat;
        logic              skip;
        logic              fault;
        logic [FW_W-1:0]   fword;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              in_exec, in_wb, is_rmw, rd_phase;
    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [SEL_W-1:0]  lk_sel;
    logic [DATA_W-1:0] ln_rval, ln_merged;
    logic              ln_skip;
    logic              miss;

    assign in_exec  = (ctl_q.st == ST_EXEC);
    assign in_wb    = (ctl_q.st == ST_WBACK);
    assign is_rmw   = (ctl_q.op == IOP_SET) || (ctl_q.op == IOP_CLR);
    assign rd_phase = in_exec && (ctl_q.op != IOP_WR);
    assign lk_addr  = (rd_phase && ctl_q.byt) ? {ctl_q.addr[ADDR_W-1:1], 1'b0} : ctl_q.addr;
    assign miss     = in_exec && !lk_hit;

    iosp_range_tbl #(
        .ADDR_W (ADDR_W),
        .NDEV   (NDEV),
        .SEL_W  (SEL_W)
    ) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_len  (cfg_len),
        .lk_addr  (lk_addr),
        .lk_hit   (lk_hit),
        .lk_sel   (lk_sel)
    );

    iosp_lane #(
        .DATA_W (DATA_W),
        .OPND_W (OPND_W)
    ) u_lane (
        .op        (ctl_q.op),
        .byte_mode (ctl_q.byt),
        .odd       (ctl_q.addr[0]),
        .rword     (dev_rdata),
        .operand   (ctl_q.opnd),
        .acc       (ctl_q.acc),
        .rval      (ln_rval),
        .merged    (ln_merged),
        .skip      (ln_skip)
    );

    iosp_adp_stat u_adp (
        .clk   (clk),
        .rst_n (rst_n),
        .miss  (miss),
        .ctrl  (ctl_q.addr[ADDR_W-1 -: CTRL_W]),
        .tmo   (adp_tmo),
        .nxd   (adp_nxd)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st   = ST_EXEC;
                    ctl_d.op   = iop_e'(req_op);
                    ctl_d.byt  = req_byte;
                    ctl_d.addr = req_addr;
                    ctl_d.opnd = req_operand;
                    ctl_d.acc  = req_acc;
                    ctl_d.user = req_user;
                end
            end
            ST_EXEC: begin
                if (!lk_hit) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.fault = 1'b1;
                    ctl_d.skip  = 1'b0;
                    ctl_d.rdat  = '0;
                    ctl_d.fword = {ctl_q.user, 1'b1,
                                   ctl_q.byt && (ctl_q.op == IOP_WR), lk_addr};
                end else if (is_rmw) begin
                    ctl_d.st   = ST_WBACK;
                    ctl_d.tmp  = ln_merged;
                    ctl_d.sel  = lk_sel;
                    ctl_d.rdat = ln_rval;
                end else begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.fault = 1'b0;
                    ctl_d.skip  = ln_skip;
                    ctl_d.rdat  = (ctl_q.op == IOP_WR) ? '0 : ln_rval;
                end
            end
            ST_WBACK: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.done  = 1'b1;
                ctl_d.fault = 1'b0;
                ctl_d.skip  = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy       = (ctl_q.st != ST_IDLE);
    assign done       = ctl_q.done;
    assign rd_data    = ctl_q.rdat;
    assign skip       = ctl_q.skip;
    assign fault      = ctl_q.fault;
    assign fault_word = ctl_q.fword;

    assign dev_rd    = rd_phase && lk_hit;
    assign dev_wr    = (in_exec && lk_hit && (ctl_q.op == IOP_WR)) || in_wb;
    assign dev_byte  = dev_wr && ctl_q.byt;
    assign dev_sel   = in_wb ? ctl_q.sel : lk_sel;
    assign dev_addr  = lk_addr;
    assign dev_wdata = in_wb ? ctl_q.tmp : ln_merged;
    assign bus_lock  = (in_exec && lk_hit && is_rmw) || in_wb;

    // R9
    rmw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && bus_lock) |-> ($past(dev_rd) && $past(bus_lock)));

    // R3
    byte_wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && dev_byte) |-> (dev_wdata[DATA_W-1:BYTE_W] == '0));

    // R4
    byte_rd_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && ctl_q.byt) |-> !dev_addr[0]);

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($past(!dev_rd) && $past(!dev_wr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/iosp_access_unit_tb.sv
`timescale 1ns/1ps
module iosp_access_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [21:0] cfg_base = '0, cfg_len = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_byte = 1'b0;
    logic [21:0] req_addr = '0;
    logic [35:0] req_operand = '0, req_acc = '0;
    logic        req_user = 1'b0;
    logic        busy, done, skip, fault, dev_rd, dev_wr, dev_byte, bus_lock;
    logic [15:0] rd_data, dev_wdata, dev_rdata;
    logic [24:0] fault_word;
    logic [1:0]  dev_sel, adp_tmo, adp_nxd;
    logic [21:0] dev_addr;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic last_wr_lock = 1'b0;
    logic [15:0] mem [4][16];

    always #2 clk = ~clk;

    iosp_access_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte), .req_addr(req_addr),
        .req_operand(req_operand), .req_acc(req_acc), .req_user(req_user),
        .busy(busy), .done(done), .rd_data(rd_data), .skip(skip), .fault(fault),
        .fault_word(fault_word),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_byte(dev_byte), .dev_sel(dev_sel),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .bus_lock(bus_lock), .adp_tmo(adp_tmo), .adp_nxd(adp_nxd)
    );

    // device model: one 16-word register file per window
    assign dev_rdata = mem[dev_sel][dev_addr[4:1]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 4; d++)
                for (int w = 0; w < 16; w++) mem[d][w] <= 16'h0;
        end else begin
            if (dev_wr) begin
                wr_cnt <= wr_cnt + 1;
                last_wr_lock <= bus_lock;
                if (!dev_byte)       mem[dev_sel][dev_addr[4:1]] <= dev_wdata;
                else if (dev_addr[0]) mem[dev_sel][dev_addr[4:1]][15:8] <= dev_wdata[7:0];
                else                 mem[dev_sel][dev_addr[4:1]][7:0]  <= dev_wdata[7:0];
            end
            if (dev_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_win(input logic [1:0] idx, input logic [21:0] base, input logic [21:0] len);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_len = len;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] op, input logic byt, input logic [21:0] addr,
                         input logic [35:0] opnd, input logic [35:0] acc, input logic user,
                         output int cyc, output int nrd, output int nwr);
        int rd0, wr0;
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_op = op; req_byte = byt; req_addr = addr;
        req_operand = opnd; req_acc = acc; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 8) begin
            @(negedge clk);
            cyc++;
        end
        nrd = rd_cnt - rd0;
        nwr = wr_cnt - wr0;
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        byt;
        logic [21:0] addr;
        logic [35:0] opnd;
        logic [35:0] acc;
        logic [15:0] exp_rd;
        logic        exp_skip;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 22'h040100, 36'hF1234ABCD, 36'h0, 16'h0000, 1'b0},
        '{3'd0, 1'b0, 22'h040100, 36'h0, 36'h0, 16'hABCD, 1'b0},
        '{3'd0, 1'b1, 22'h040101, 36'h0, 36'h0, 16'h00AB, 1'b0},
        '{3'd0, 1'b1, 22'h040100, 36'h0, 36'h0, 16'h00CD, 1'b0},
        '{3'd1, 1'b1, 22'h040103, 36'h123, 36'h0, 16'h0000, 1'b0},
        '{3'd0, 1'b0, 22'h040102, 36'h0, 36'h0, 16'h2300, 1'b0},
        '{3'd4, 1'b0, 22'h040102, 36'h00F0, 36'h0, 16'h2300, 1'b0},
        '{3'd0, 1'b0, 22'h040102, 36'h0, 36'h0, 16'h23F0, 1'b0},
        '{3'd5, 1'b1, 22'h040103, 36'h21, 36'h0, 16'h0023, 1'b0},
        '{3'd0, 1'b0, 22'h040102, 36'h0, 36'h0, 16'h02F0, 1'b0},
        '{3'd4, 1'b1, 22'h040100, 36'h02, 36'h0, 16'h00CD, 1'b0},
        '{3'd0, 1'b0, 22'h040100, 36'h0, 36'h0, 16'hABCF, 1'b0},
        '{3'd5, 1'b0, 22'h040100, 36'hFF00, 36'h0, 16'hABCF, 1'b0},
        '{3'd0, 1'b0, 22'h040100, 36'h0, 36'h0, 16'h00CF, 1'b0},
        '{3'd2, 1'b0, 22'h040100, 36'h0, 36'h30, 16'h00CF, 1'b1},
        '{3'd2, 1'b0, 22'h040100, 36'h0, 36'h1, 16'h00CF, 1'b0},
        '{3'd3, 1'b0, 22'h040100, 36'h0, 36'h1, 16'h00CF, 1'b1},
        '{3'd3, 1'b0, 22'h040100, 36'h0, 36'h0F00, 16'h00CF, 1'b0},
        '{3'd3, 1'b1, 22'h040101, 36'h0, 36'hFF30, 16'h0000, 1'b0},
        '{3'd2, 1'b1, 22'h040100, 36'h0, 36'hF00000030, 16'h00CF, 1'b1},
        '{3'd1, 1'b0, 22'h0C0204, 36'h1111, 36'h0, 16'h0000, 1'b0},
        '{3'd1, 1'b0, 22'h0C0208, 36'h2222, 36'h0, 16'h0000, 1'b0},
        '{3'd0, 1'b0, 22'h0C0204, 36'h0, 36'h0, 16'h1111, 1'b0},
        '{3'd0, 1'b0, 22'h0C0208, 36'h0, 36'h0, 16'h2222, 1'b0},
        '{3'd0, 1'b0, 22'h04010E, 36'h0, 36'h0, 16'h0000, 1'b0},
        '{3'd0, 1'b0, 22'h0C021E, 36'h0, 36'h0, 16'h0000, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc, nrd, nwr, ecyc, erd, ewr;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done, "R11 reset busy/done", {busy, done}, 0);
        check(adp_tmo == 0 && adp_nxd == 0, "R11 reset adapter status", {adp_tmo, adp_nxd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dev_rd && !dev_wr, "R11 idle strobes", {dev_rd, dev_wr}, 0);

        // R11 window loading; entry 2 overlaps entry 1 (R2)
        load_win(2'd0, 22'h040100, 22'd16);
        load_win(2'd1, 22'h0C0200, 22'd8);
        load_win(2'd2, 22'h0C0200, 22'd32);
        load_win(2'd3, 22'h080000, 22'd0);

        // R1 R3 R4 R5 R6 R10: vector walk
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].byt, VECS[i].addr, VECS[i].opnd, VECS[i].acc, 1'b0,
                  cyc, nrd, nwr);
            ecyc = (VECS[i].op >= 3'd4) ? 3 : 2;
            erd  = (VECS[i].op == 3'd1) ? 0 : 1;
            ewr  = (VECS[i].op == 3'd1 || VECS[i].op >= 3'd4) ? 1 : 0;
            check(rd_data == VECS[i].exp_rd, "R1/R3/R4/R5 rd_data", rd_data, VECS[i].exp_rd);
            check(skip == VECS[i].exp_skip, "R6 skip", skip, VECS[i].exp_skip);
            check(!fault, "R1 no fault on hit", fault, 0);
            check(cyc == ecyc, "R10 latency", cyc, ecyc);
            check(nrd == erd && nwr == ewr, "R6 strobe counts", {nrd[7:0], nwr[7:0]}, {erd[7:0], ewr[7:0]});
        end

        // R2 overlap: 0C0204 went to window 1, 0C0208 to window 2
        check(mem[1][2] == 16'h1111, "R2 low index owns overlap", mem[1][2], 16'h1111);
        check(mem[2][2] == 16'h0000, "R2 higher index untouched", mem[2][2], 0);
        check(mem[2][4] == 16'h2222, "R2 beyond low window", mem[2][4], 16'h2222);
        check(mem[0][1] == 16'h02F0, "R5 byte merge lane", mem[0][1], 16'h02F0);

        // R7 R8: byte write miss, controller 2 has no adapter
        do_op(3'd1, 1'b1, 22'h080010, 36'h5, 36'h0, 1'b0, cyc, nrd, nwr);
        check(fault && cyc == 2, "R7 miss fault", {fault, cyc[3:0]}, {1'b1, 4'd2});
        check(fault_word == {1'b0, 1'b1, 1'b1, 22'h080010}, "R7 fault word byte write", fault_word,
              {1'b0, 1'b1, 1'b1, 22'h080010});
        check(nrd == 0 && nwr == 0, "R7 no strobes on miss", {nrd[7:0], nwr[7:0]}, 0);
        check(adp_tmo == 2'b00 && adp_nxd == 2'b00, "R8 controller 2 no adapter", {adp_tmo, adp_nxd}, 0);

        // R7 R8: byte read miss, user mode, controller 1 -> adapter 0
        do_op(3'd0, 1'b1, 22'h040111, 36'h0, 36'h0, 1'b1, cyc, nrd, nwr);
        check(fault_word == {1'b1, 1'b1, 1'b0, 22'h040110}, "R7 fault word byte read user", fault_word,
              {1'b1, 1'b1, 1'b0, 22'h040110});
        check(adp_tmo == 2'b01 && adp_nxd == 2'b01, "R8 adapter 0 flags", {adp_tmo, adp_nxd}, 4'b0101);

        // R8: word read miss past window 2 end, controller 3 -> adapter 1
        do_op(3'd0, 1'b0, 22'h0C0220, 36'h0, 36'h0, 1'b0, cyc, nrd, nwr);
        check(fault && rd_data == 0, "R7 miss read result", {fault, rd_data}, {1'b1, 16'h0});
        check(adp_tmo == 2'b11 && adp_nxd == 2'b11, "R8 adapter 1 flags sticky", {adp_tmo, adp_nxd}, 4'b1111);

        // R9: lock on read-modify-write, none on plain write
        do_op(3'd1, 1'b0, 22'h04010C, 36'h0005, 36'h0, 1'b0, cyc, nrd, nwr);
        check(last_wr_lock == 1'b0, "R9 plain write unlocked", last_wr_lock, 0);

        // R9: request offered while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_byte = 1'b0; req_addr = 22'h04010C;
        req_operand = 36'h0; req_acc = 36'h0;
        @(negedge clk);
        check(busy, "R9 busy after accept", busy, 1);
        req_op = 3'd1; req_operand = 36'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(done && last_wr_lock, "R9 rmw done and locked write", {done, last_wr_lock}, 2'b11);
        repeat (2) @(negedge clk);
        check(!busy, "R9 no second op started", busy, 0);
        check(mem[0][6] == 16'h0005, "R9 ignored write left value", mem[0][6], 16'h0005);

        // R11: reload a window at run time
        load_win(2'd3, 22'h080000, 22'd4);
        do_op(3'd1, 1'b0, 22'h080002, 36'h7777, 36'h0, 1'b0, cyc, nrd, nwr);
        check(!fault && mem[3][1] == 16'h7777, "R11 reloaded window", {fault, mem[3][1]}, {1'b0, 16'h7777});

        // R11: reset clears table and status
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done && adp_tmo == 0 && adp_nxd == 0, "R11 reset clears status",
              {busy, done, adp_tmo, adp_nxd}, 0);
        rst_n = 1'b1;
        do_op(3'd0, 1'b0, 22'h040100, 36'h0, 36'h0, 1'b0, cyc, nrd, nwr);
        check(fault, "R11 table cleared by reset", fault, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule